// File: doc/BRIEF.md
# Trigger Busy Readout Controller

This block runs the busy handshake of a single-buffer event readout board in a triggered acquisition crate. A first-level accept marks the board busy and raises an interrupt request. The controller then waits for the second-level decision. An accept opens a transfer window by driving the active-low slave-ready line. A reject drops the event at once and frees the board. The board leaves busy when the downstream event buffer driver reports that the transfer is complete. A crate-wide init pulse returns the controller to idle from any state, including a transfer that has hung.

A small register port lets software read the controller state and the overrun count. Software can also write a command register, which issues single-cycle software slave-ready and slave-finished strobes and clears the interrupt. A read is always acknowledged and never changes anything. A stretched indicator output shows real second-level accepts.

Top module: `trig_busy_ctrl`

## Requirements
- R1: After reset, l1_busy is 0, slv_rdy_n is 1, irq is 0, led_l2_acc is 0, and the overrun count reads 0.
- R2: An l1_accept sampled while idle sets l1_busy in the next cycle and moves the controller to state code 1 (waiting for the second-level decision).
- R3: An l2_accept sampled in state 1 drives slv_rdy_n low in the next cycle (state code 2). slv_rdy_n stays low until a transfer completion or crate_init is sampled.
- R4: An xfer_done sampled in state 2 raises slv_rdy_n and drops l1_busy in the next cycle. The controller spends one cycle in state code 3 and then returns to idle (state code 0).
- R5: An l2_reject sampled in state 1 drops l1_busy in the next cycle and returns to idle without asserting slv_rdy_n. A reject has priority over an accept that arrives in the same cycle.
- R6: crate_init has priority over every other input. In the next cycle the controller is idle, l1_busy is 0, slv_rdy_n is 1 and irq is 0.
- R7: irq is a level that is set in the cycle after an l1_accept is taken. It stays set until a command write with bit 2 set, or until crate_init. A transfer completion, whether from hardware or from software, does not set it.
- R8: An l1_accept sampled while not idle leaves the state unchanged and increments the overrun count. The count saturates at 2^OVR_W-1. crate_init does not clear it.
- R9: A read request is acknowledged one cycle later with bus_rdata valid. No read, at any address, changes state, irq or the strobes. The read map is: address 0 returns status, with the state code in bits [1:0], busy in bit 2, irq in bit 3 and slave-ready-active in bit 4. Address 1 reads 0. Address 2 returns the overrun count.
- R10: A write to address 1 turns bit 0 into a software slave-ready strobe, bit 1 into a software slave-finished strobe and bit 2 into an interrupt clear. The strobe is active in the cycle after the request, and bus_ack is high one cycle after the strobe. The software slave-ready moves state 1 to state 2, and the software slave-finished completes a transfer in state 2. Both strobes have no effect in any other state.
- R11: led_l2_acc rises in the cycle after an l2_accept is taken in state 1 and stays high for LED_HOLD cycles. It is not raised by an l2_reject, by an l2_accept outside state 1, or by a software slave-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_accept | input | 1 | First-level accept strobe |
| l2_accept | input | 1 | Second-level accept strobe |
| l2_reject | input | 1 | Second-level reject strobe |
| crate_init | input | 1 | Crate-wide init strobe |
| xfer_done | input | 1 | Transfer-complete strobe from the buffer driver |
| bus_valid | input | 1 | Register request strobe (one cycle per request) |
| bus_write | input | 1 | 1 for a write request, 0 for a read request |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Request acknowledge |
| bus_rdata | output | DATA_W | Read data, valid while bus_ack is high after a read |
| l1_busy | output | 1 | First-level busy |
| slv_rdy_n | output | 1 | Active-low slave ready |
| irq | output | 1 | Interrupt request level |
| led_l2_acc | output | 1 | Stretched second-level accept indicator |

## Verification
The bench builds the block with OVR_W set to 2 and LED_HOLD set to 4. With the 2-bit overrun counter, a few extra first-level accepts are enough to reach the saturation point and to show that the counter survives an init. With the short hold, the bench can count the exact indicator window cycle by cycle. Both changes keep the state machine and the register timing the same as with the defaults.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_L2 = 2'd1,
        ST_XFER    = 2'd2,
        ST_DONE    = 2'd3
    } seq_state_e;

    localparam int REG_STATUS = 0;
    localparam int REG_CMD    = 1;
    localparam int REG_OVR    = 2;

    localparam int CMD_SW_RDY  = 0;
    localparam int CMD_SW_FIN  = 1;
    localparam int CMD_IRQ_CLR = 2;

    localparam int STAT_BUSY = 2;
    localparam int STAT_IRQ  = 3;
    localparam int STAT_RDY  = 4;
    localparam int STAT_W    = 5;

    typedef struct packed {
        logic sw_rdy;
        logic sw_fin;
        logic irq_clr;
    } cmd_t;

    function automatic logic state_busy(seq_state_e s);
        return (s == ST_WAIT_L2) || (s == ST_XFER);
    endfunction

    function automatic logic state_ready(seq_state_e s);
        return s == ST_XFER;
    endfunction

endpackage

// File: rtl/tbc_seq.sv
module tbc_seq
    import tbc_pkg::*;
#(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             l1_accept,
    input  logic             l2_accept,
    input  logic             l2_reject,
    input  logic             crate_init,
    input  logic             xfer_done,
    input  cmd_t             cmd,
    output seq_state_e       state,
    output logic             irq,
    output logic [OVR_W-1:0] ovr_cnt,
    output logic             l2_taken
);

    localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

    seq_state_e state_q, state_d;
    logic       irq_q;
    logic [OVR_W-1:0] ovr_q;
    logic       l1_take;
    logic       ovr_evt;

    assign l1_take = (state_q == ST_IDLE) && l1_accept && !crate_init;
    assign ovr_evt = (state_q != ST_IDLE) && l1_accept && !crate_init;

    always_comb begin
        state_d  = state_q;
        l2_taken = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (l1_accept) state_d = ST_WAIT_L2;
            end
            ST_WAIT_L2: begin
                if (l2_reject) begin
                    state_d = ST_IDLE;
                end else if (l2_accept) begin
                    state_d  = ST_XFER;
                    l2_taken = 1'b1;
                end else if (cmd.sw_rdy) begin
                    state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (xfer_done || cmd.sw_fin) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (crate_init) begin
            state_d  = ST_IDLE;
            l2_taken = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b0;
            ovr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (crate_init) begin
                irq_q <= 1'b0;
            end else if (l1_take) begin
                irq_q <= 1'b1;
            end else if (cmd.irq_clr) begin
                irq_q <= 1'b0;
            end
            if (ovr_evt && (ovr_q != OVR_MAX)) begin
                ovr_q <= ovr_q + 1'b1;
            end
        end
    end

    assign state   = state_q;
    assign irq     = irq_q;
    assign ovr_cnt = ovr_q;

    AST_L1_TAKE: assert property (@(posedge clk) disable iff (rst) // R2
        (state_q == ST_IDLE && l1_accept && !crate_init) |=> (state_q == ST_WAIT_L2 && irq_q))
        else $error("l1 accept not taken");

    AST_RDY_HELD: assert property (@(posedge clk) disable iff (rst) // R3
        (state_q == ST_XFER && !xfer_done && !cmd.sw_fin && !crate_init) |=> (state_q == ST_XFER))
        else $error("transfer window dropped early");

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst) // R4
        (state_q == ST_DONE) |=> (state_q == ST_IDLE))
        else $error("done state lingered");

    AST_REJECT_DROP: assert property (@(posedge clk) disable iff (rst) // R5
        (state_q == ST_WAIT_L2 && l2_reject && !crate_init) |=> (state_q == ST_IDLE))
        else $error("reject did not free the board");

    AST_INIT_IDLE: assert property (@(posedge clk) disable iff (rst) // R6
        crate_init |=> (state_q == ST_IDLE && !irq_q))
        else $error("init did not return to idle");

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst) // R7
        (irq_q && !cmd.irq_clr && !crate_init) |=> irq_q)
        else $error("irq dropped without a clear");

    AST_OVR_NO_WRAP: assert property (@(posedge clk) disable iff (rst) // R8
        (ovr_q == OVR_MAX) |=> (ovr_q == OVR_MAX))
        else $error("overrun counter wrapped");

    AST_OVR_STATE_KEPT: assert property (@(posedge clk) disable iff (rst) // R8
        (state_q == ST_WAIT_L2 && l1_accept && !l2_accept && !l2_reject && !cmd.sw_rdy && !crate_init)
        |=> (state_q == ST_WAIT_L2))
        else $error("late l1 accept changed state");

endmodule

// File: rtl/tbc_bus_port.sv
module tbc_bus_port
    import tbc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int OVR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  seq_state_e        state,
    input  logic              irq,
    input  logic [OVR_W-1:0]  ovr_cnt,
    output cmd_t              cmd
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] A_OVR    = ADDR_W'(REG_OVR);

    logic              wr_pend_q;
    logic              ack_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    cmd_t              cmd_q;
    logic              rd_req;
    logic              wr_req;
    logic              unused_wdata;

    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid && bus_write;
    assign unused_wdata = ^bus_wdata[DATA_W-1:3];

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_STATUS) begin
            rd_mux[1:0]       = state;
            rd_mux[STAT_BUSY] = state_busy(state);
            rd_mux[STAT_IRQ]  = irq;
            rd_mux[STAT_RDY]  = state_ready(state);
        end else if (bus_addr == A_OVR) begin
            rd_mux = DATA_W'(ovr_cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend_q <= 1'b0;
            ack_q     <= 1'b0;
            rdata_q   <= '0;
            cmd_q     <= '0;
        end else begin
            cmd_q     <= '0;
            wr_pend_q <= wr_req;
            ack_q     <= wr_pend_q || rd_req;
            if (wr_req && bus_addr == A_CMD) begin
                cmd_q.sw_rdy  <= bus_wdata[CMD_SW_RDY];
                cmd_q.sw_fin  <= bus_wdata[CMD_SW_FIN];
                cmd_q.irq_clr <= bus_wdata[CMD_IRQ_CLR];
            end
            if (rd_req) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;
    assign cmd       = cmd_q;

    AST_READ_NO_CMD: assert property (@(posedge clk) disable iff (rst) // R9
        (bus_valid && !bus_write) |=> (cmd_q == '0))
        else $error("read produced a command strobe");

    AST_READ_ACK: assert property (@(posedge clk) disable iff (rst) // R9
        (bus_valid && !bus_write) |=> ack_q)
        else $error("read not acknowledged");

    AST_WR_ACK_LAG: assert property (@(posedge clk) disable iff (rst) // R10
        (cmd_q != '0) |=> ack_q)
        else $error("write ack did not follow strobe");

    initial begin
        AST_DATA_FITS: assert (DATA_W >= STAT_W && DATA_W >= OVR_W && DATA_W >= 3) // R9
            else $error("data width too small");
    end

endmodule

// File: rtl/tbc_led_stretch.sv
module tbc_led_stretch #(
    parameter int HOLD = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic led
);

    localparam int CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= CNT_W'(HOLD);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign led = (cnt_q != '0);

    AST_LED_SOURCE: assert property (@(posedge clk) disable iff (rst) // R11
        $rose(led) |-> $past(trig))
        else $error("indicator rose without a real accept");

endmodule

// File: rtl/trig_busy_ctrl.sv
module trig_busy_ctrl
    import tbc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int OVR_W    = 8,
    parameter int LED_HOLD = 12_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l1_accept,
    input  logic              l2_accept,
    input  logic              l2_reject,
    input  logic              crate_init,
    input  logic              xfer_done,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              l1_busy,
    output logic              slv_rdy_n,
    output logic              irq,
    output logic              led_l2_acc
);

    seq_state_e       state;
    cmd_t             cmd;
    logic [OVR_W-1:0] ovr_cnt;
    logic             l2_taken;

    tbc_seq #(.OVR_W(OVR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .l1_accept  (l1_accept),
        .l2_accept  (l2_accept),
        .l2_reject  (l2_reject),
        .crate_init (crate_init),
        .xfer_done  (xfer_done),
        .cmd        (cmd),
        .state      (state),
        .irq        (irq),
        .ovr_cnt    (ovr_cnt),
        .l2_taken   (l2_taken)
    );

    tbc_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVR_W(OVR_W)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .state     (state),
        .irq       (irq),
        .ovr_cnt   (ovr_cnt),
        .cmd       (cmd)
    );

    tbc_led_stretch #(.HOLD(LED_HOLD)) u_led (
        .clk  (clk),
        .rst  (rst),
        .trig (l2_taken),
        .led  (led_l2_acc)
    );

    assign l1_busy   = state_busy(state);
    assign slv_rdy_n = !state_ready(state);

    AST_RDY_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst) // R5
        (l1_busy && !slv_rdy_n) |=> (l1_busy || slv_rdy_n))
        else $error("slave ready left busy window");

    AST_FIN_RELEASE: assert property (@(posedge clk) disable iff (rst) // R4
        (!slv_rdy_n && xfer_done) |=> (slv_rdy_n && !l1_busy))
        else $error("transfer completion not honoured");

endmodule

// File: tb/trig_busy_ctrl_tb.sv
module trig_busy_ctrl_tb;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int OVR_W  = 2;
    localparam int HOLD   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l1_accept = 0, l2_accept = 0, l2_reject = 0, crate_init = 0, xfer_done = 0;
    logic bus_valid = 0, bus_write = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic bus_ack;
    logic [DATA_W-1:0] bus_rdata;
    logic l1_busy, slv_rdy_n, irq, led_l2_acc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    trig_busy_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVR_W(OVR_W), .LED_HOLD(HOLD)) u_dut (
        .clk(clk), .rst(rst), .l1_accept(l1_accept), .l2_accept(l2_accept),
        .l2_reject(l2_reject), .crate_init(crate_init), .xfer_done(xfer_done),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .l1_busy(l1_busy), .slv_rdy_n(slv_rdy_n), .irq(irq), .led_l2_acc(led_l2_acc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0=l1_accept 1=l2_accept 2=l2_reject 3=crate_init 4=xfer_done
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: l1_accept = 1; 1: l2_accept = 1; 2: l2_reject = 1;
            3: crate_init = 1; default: xfer_done = 1;
        endcase
        @(negedge clk);
        {l1_accept, l2_accept, l2_reject, crate_init, xfer_done} = '0;
    endtask

    task automatic rd(input int addr, input int junk, output int data);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = ADDR_W'(addr); bus_wdata = DATA_W'(junk);
        @(negedge clk);
        bus_valid = 0; bus_wdata = '0;
        eq("R9 read ack", int'(bus_ack), 1);
        data = int'(bus_rdata);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = ADDR_W'(addr); bus_wdata = DATA_W'(data);
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_wdata = '0;
        eq("R10 no ack on strobe cycle", int'(bus_ack), 0);
        @(negedge clk);
        eq("R10 write ack after strobe", int'(bus_ack), 1);
    endtask

    task automatic t_reset();
        int d;
        rst = 1; idle(3); rst = 0;
        eq("R1 busy", int'(l1_busy), 0);
        eq("R1 slv_rdy_n", int'(slv_rdy_n), 1);
        eq("R1 irq", int'(irq), 0);
        eq("R1 led", int'(led_l2_acc), 0);
        rd(2, 0, d); eq("R1 overrun count", d, 0);
    endtask

    task automatic t_normal();
        int d;
        pulse(0);
        eq("R2 busy after l1", int'(l1_busy), 1);
        eq("R7 irq after l1", int'(irq), 1);
        eq("R2 slv idle", int'(slv_rdy_n), 1);
        rd(0, 0, d); eq("R2 status state", d & 3, 1);
        pulse(1);
        eq("R3 slv low", int'(slv_rdy_n), 0);
        idle(4);
        eq("R3 slv held", int'(slv_rdy_n), 0);
        rd(0, 0, d); eq("R9 status in transfer", d, 5'b11110);
        pulse(4);
        eq("R4 slv released", int'(slv_rdy_n), 1);
        eq("R4 busy released", int'(l1_busy), 0);
        rd(0, 0, d); eq("R4 back to idle", d & 7, 0);
        eq("R7 irq kept after finish", (d >> 3) & 1, 1);
        wr(1, 4);
        eq("R7 irq cleared by write", int'(irq), 0);
        idle(HOLD + 1);
    endtask

    task automatic t_reject();
        int d;
        pulse(0);
        pulse(2);
        eq("R5 busy dropped", int'(l1_busy), 0);
        eq("R5 slv not asserted", int'(slv_rdy_n), 1);
        eq("R11 no led on reject", int'(led_l2_acc), 0);
        rd(0, 0, d); eq("R5 idle", d & 3, 0);
        // both decisions at once: reject wins
        pulse(0);
        @(negedge clk); l2_accept = 1; l2_reject = 1;
        @(negedge clk); l2_accept = 0; l2_reject = 0;
        eq("R5 reject priority busy", int'(l1_busy), 0);
        eq("R5 reject priority slv", int'(slv_rdy_n), 1);
        wr(1, 4);
    endtask

    task automatic t_init_hang();
        pulse(0); pulse(1);
        idle(6);
        eq("R6 hung transfer slv low", int'(slv_rdy_n), 0);
        @(negedge clk); crate_init = 1; xfer_done = 1; l1_accept = 1;
        @(negedge clk); crate_init = 0; xfer_done = 0; l1_accept = 0;
        eq("R6 slv released", int'(slv_rdy_n), 1);
        eq("R6 busy low", int'(l1_busy), 0);
        eq("R6 irq low", int'(irq), 0);
        idle(HOLD + 1);
    endtask

    task automatic t_overrun();
        int d;
        pulse(0);
        for (int i = 0; i < 4; i++) pulse(0);
        rd(2, 0, d); eq("R8 overrun saturates", d, 3);
        rd(0, 0, d); eq("R8 state unchanged", d & 3, 1);
        pulse(3);
        rd(2, 0, d); eq("R8 count survives init", d, 3);
    endtask

    task automatic t_read_noeffect();
        int d;
        pulse(0);
        rd(1, 7, d); eq("R9 command reads zero", d, 0);
        rd(0, 7, d); eq("R9 read left state", d & 3, 1);
        eq("R9 read left irq", int'(irq), 1);
        eq("R9 read left slv", int'(slv_rdy_n), 1);
        pulse(2);
        wr(1, 4);
    endtask

    task automatic t_sw_cmd();
        int d;
        wr(1, 2);
        rd(0, 0, d); eq("R10 finish ignored in idle", d, 0);
        pulse(0);
        wr(1, 1);
        eq("R10 sw ready slv", int'(slv_rdy_n), 0);
        eq("R11 no led on sw ready", int'(led_l2_acc), 0);
        wr(1, 2);
        eq("R10 sw finish slv", int'(slv_rdy_n), 1);
        eq("R10 sw finish busy", int'(l1_busy), 0);
        eq("R7 irq not from finish path", int'(irq), 1);
        wr(1, 4);
        eq("R7 irq clear", int'(irq), 0);
    endtask

    task automatic t_led();
        pulse(1);
        eq("R11 no led on stray accept", int'(led_l2_acc), 0);
        eq("R11 stray accept no slv", int'(slv_rdy_n), 1);
        pulse(0); pulse(1);
        eq("R11 led rises", int'(led_l2_acc), 1);
        idle(HOLD - 1);
        eq("R11 led held", int'(led_l2_acc), 1);
        idle(1);
        eq("R11 led drops after hold", int'(led_l2_acc), 0);
        pulse(4);
        wr(1, 4);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_reject();
        t_init_hang();
        t_overrun();
        t_read_noeffect();
        t_sw_cmd();
        t_led();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule